// File: doc/BRIEF.md
# Repair Fuse Word Programmer

This block is the permanent-storage end of a memory self-repair flow. Each embedded memory keeps its repair settings in a serial fuse register, and the registers of all memories are linked into one scan chain. On a program command the block shifts the whole chain once. It feeds the chain output back to the chain input so the soft-repair settings are not lost. It cuts the bits of every repaired memory into words of the fuse array width and writes each word through a request/acknowledge handshake. Memories with no repair take no space in the array.

On a load command, issued at power-up, the block walks the stored records and restores each one into its memory. For each record it opens only the target memory in the chain and puts every other register in bypass. A memory with no record keeps its reset value. Programming may be repeated after more repairs. The new records are appended after the existing ones, and a memory that already has a record is never written again.

Top module: `fuse_rom_programmer`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `chain_shift` and `rom_wr_req` are 0.
- R2: A program pass shifts the chain exactly NUM_MEM*FUSE_LEN times with `chain_si` equal to `chain_so`, and all bypasses open, so every fuse register holds its original contents afterwards.
- R3: The chain emits memory 0 first, and each register emits its bit 0 first. A memory is repaired when its bit 0 is 1. Only repaired memories get a record.
- R4: A record is one header word followed by ceil(FUSE_LEN/ROM_W) data words. The header has bit ROM_W-1 set, the memory index in its low bits and zeros elsewhere. Data bit j of the register goes to data word j/ROM_W at bit j%ROM_W, and unused high bits of the last word are 0. Records go to consecutive addresses in chain order.
- R5: Before writing, a pass reads from address 0 and steps one record at a time until it finds an all-zero word or the end of the array. New records start at that address. Words below it are never written, and a memory that already has a record there gets no new one.
- R6: A record is written only if all of its words fit below ROM_DEPTH. Otherwise it is skipped whole, and no write is ever issued at an address of ROM_DEPTH or above.
- R7: `rom_wr_req` stays high with stable `rom_addr` and `rom_wdata` until `rom_wr_ack` is seen. `chain_shift` is never high while a write is pending.
- R8: A load pass reads the records in order. For each one it shifts FUSE_LEN stored bits into the indexed memory, bit 0 first, while exactly one memory is out of bypass.
- R9: During a load, a memory with no stored record is never shifted and keeps its previous value.
- R10: At the end of either pass `done` is high for exactly one cycle, and `busy` is low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prog_start | input | 1 | Start a program pass (taken when idle) |
| load_start | input | 1 | Start a load pass (taken when idle; program wins) |
| busy | output | 1 | A pass is in progress |
| done | output | 1 | One-cycle end-of-pass pulse |
| chain_shift | output | 1 | Shift enable for the non-bypassed fuse registers |
| chain_si | output | 1 | Serial data into the top of the chain |
| chain_so | input | 1 | Serial data out of the chain (memory 0 side) |
| mem_bypass | output | NUM_MEM | Per-memory bypass select, 1 = skipped and held |
| rom_addr | output | clog2(ROM_DEPTH) | Fuse array word address for read and write |
| rom_rdata | input | ROM_W | Fuse array read data for `rom_addr` (combinational) |
| rom_wr_req | output | 1 | Word write request |
| rom_wdata | output | ROM_W | Word to program |
| rom_wr_ack | input | 1 | Write accepted |

## Verification
The assertions check the handshake rules on every cycle: the request is held with stable address and data, the chain is never shifted while a write is pending, writes stay inside the array, and at most one memory is open during a load. They also check the quiet idle state and the single-cycle `done` pulse. The bench shows the things no single cycle reveals. It checks the full word layout of the array after each pass, and that the chain is restored after programming. It also checks that records are appended without duplicating memories already stored, that a record which would overflow the array is dropped, and that a load with records stored out of memory order rebuilds every register while unrepaired ones stay cleared.

// File: rtl/fpg_pkg.sv
// Shared types for the repair fuse word programmer.
// Assumes: nothing beyond IEEE 1800-2017.
package fpg_pkg;

    // Controller sequencing states
    typedef enum logic [2:0] {
        S_IDLE,
        S_SCAN,
        S_PSHIFT,
        S_PWR,
        S_LHDR,
        S_LDATA,
        S_DONE
    } fpg_state_e;

endpackage

// File: rtl/fpg_pos_counter.sv
// Position tracker for the serial stream: bit within the current fuse
// register, bit within the current fuse word, and the memory index.
// Assumes FUSE_LEN >= 2 and ROM_W >= 2; a word ends at a register end.
module fpg_pos_counter #(
    parameter int FUSE_LEN = 6,
    parameter int ROM_W    = 4,
    parameter int NUM_MEM  = 4,
    parameter int BIT_W    = $clog2(FUSE_LEN),
    parameter int POS_W    = $clog2(ROM_W),
    parameter int MC_W     = $clog2(NUM_MEM + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    output logic [BIT_W-1:0] bit_idx,
    output logic [POS_W-1:0] wpos,
    output logic [MC_W-1:0]  mem_idx,
    output logic             last_bit,
    output logic             word_end,
    output logic             last_mem,
    output logic             all_done
);

    // Boundary decodes of the current position
    always_comb begin
        last_bit = (bit_idx == BIT_W'(FUSE_LEN - 1));
        word_end = last_bit || (wpos == POS_W'(ROM_W - 1));
        last_mem = (mem_idx == MC_W'(NUM_MEM - 1));
        all_done = (mem_idx == MC_W'(NUM_MEM));
    end

    // Advance one bit per step, wrapping word and register positions
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            bit_idx <= '0;
            wpos    <= '0;
            mem_idx <= '0;
        end else if (step) begin
            if (last_bit) begin
                bit_idx <= '0;
                wpos    <= '0;
                mem_idx <= mem_idx + 1'b1;
            end else begin
                bit_idx <= bit_idx + 1'b1;
                wpos    <= word_end ? '0 : wpos + 1'b1;
            end
        end
    end

endmodule

// File: rtl/fpg_word_buf.sv
// Word assembly buffer: collects serial bits at given positions into one
// fuse word; unfilled positions stay 0 and give the padding.
// Assumes clear and put are never asserted together.
module fpg_word_buf #(
    parameter int ROM_W = 4,
    parameter int POS_W = $clog2(ROM_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             put,
    input  logic [POS_W-1:0] pos,
    input  logic             din,
    output logic [ROM_W-1:0] word
);

    for (genvar b = 0; b < ROM_W; b++) begin : g_bit
        // Hold or capture one bit of the word
        always_ff @(posedge clk) begin
            if (!rst_n || clear)
                word[b] <= 1'b0;
            else if (put && (pos == POS_W'(b)))
                word[b] <= din;
        end
    end

endmodule

// File: rtl/fuse_rom_programmer.sv
// Moves per-memory repair settings between a serial fuse register chain
// and a word-wide fuse array. A program pass finds the end of stored
// records, shifts the chain once with recirculation and appends a record
// for each newly repaired memory. A load pass replays the records into
// the chain with all but the target memory bypassed.
// Assumes: ROM_W > clog2(NUM_MEM), FUSE_LEN >= 2, fuse array read is
// combinational, unprogrammed words read as zero.
module fuse_rom_programmer #(
    parameter int NUM_MEM   = 4,
    parameter int FUSE_LEN  = 6,
    parameter int ROM_W     = 4,
    parameter int ROM_DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         prog_start,
    input  logic                         load_start,
    output logic                         busy,
    output logic                         done,
    output logic                         chain_shift,
    output logic                         chain_si,
    input  logic                         chain_so,
    output logic [NUM_MEM-1:0]           mem_bypass,
    output logic [$clog2(ROM_DEPTH)-1:0] rom_addr,
    input  logic [ROM_W-1:0]             rom_rdata,
    output logic                         rom_wr_req,
    output logic [ROM_W-1:0]             rom_wdata,
    input  logic                         rom_wr_ack
);
    import fpg_pkg::*;

    localparam int IDX_W     = (NUM_MEM > 1) ? $clog2(NUM_MEM) : 1;
    localparam int DATA_WRDS = (FUSE_LEN + ROM_W - 1) / ROM_W;
    localparam int REC_WRDS  = 1 + DATA_WRDS;
    localparam int AW        = $clog2(ROM_DEPTH);
    localparam int CW        = $clog2(ROM_DEPTH + REC_WRDS + 1);
    localparam int BIT_W     = $clog2(FUSE_LEN);
    localparam int POS_W     = $clog2(ROM_W);
    localparam int MC_W      = $clog2(NUM_MEM + 1);

    fpg_state_e           state;
    logic [CW-1:0]        addr;
    logic [NUM_MEM-1:0]   stored;
    logic                 rec_on, hdr_pend, word_pend;
    logic [IDX_W-1:0]     rec_mem, ld_idx;
    logic [ROM_W-1:0]     wbuf, hdr_word;
    logic [BIT_W-1:0]     bit_idx;
    logic [POS_W-1:0]     wpos;
    logic [MC_W-1:0]      mem_idx;
    logic                 last_bit, word_end, last_mem, all_done;
    logic                 ctr_clear, ctr_step, buf_clear, buf_put;
    logic                 rd_end, rd_ok, idx_in_range, fits, cap_rec;
    logic [IDX_W-1:0]     rd_idx;

    fpg_pos_counter #(
        .FUSE_LEN(FUSE_LEN), .ROM_W(ROM_W), .NUM_MEM(NUM_MEM),
        .BIT_W(BIT_W), .POS_W(POS_W), .MC_W(MC_W)
    ) pos_i (
        .clk(clk), .rst_n(rst_n), .clear(ctr_clear), .step(ctr_step),
        .bit_idx(bit_idx), .wpos(wpos), .mem_idx(mem_idx),
        .last_bit(last_bit), .word_end(word_end),
        .last_mem(last_mem), .all_done(all_done)
    );

    fpg_word_buf #(.ROM_W(ROM_W), .POS_W(POS_W)) wbuf_i (
        .clk(clk), .rst_n(rst_n), .clear(buf_clear), .put(buf_put),
        .pos(wpos), .din(chain_so), .word(wbuf)
    );

    assign rd_idx = rom_rdata[IDX_W-1:0];

    if (NUM_MEM == (1 << IDX_W)) begin : g_full_idx
        assign idx_in_range = 1'b1;
    end else begin : g_part_idx
        assign idx_in_range = (int'(rd_idx) < NUM_MEM);
    end

    // Decodes of the word under the read pointer and space left
    always_comb begin
        rd_end  = (int'(addr) >= ROM_DEPTH) || (rom_rdata == '0);
        rd_ok   = rom_rdata[ROM_W-1] && idx_in_range;
        fits    = (int'(addr) + REC_WRDS) <= ROM_DEPTH;
        cap_rec = (bit_idx == '0)
                ? (chain_so && !stored[mem_idx[IDX_W-1:0]] && fits)
                : rec_on;
    end

    // Header word: marker bit on top, memory index at the bottom
    always_comb begin
        hdr_word              = '0;
        hdr_word[IDX_W-1:0]   = rec_mem;
        hdr_word[ROM_W-1]     = 1'b1;
    end

    // Counter and buffer controls from the current state
    always_comb begin
        ctr_clear = (state == S_IDLE) || (state == S_SCAN) || (state == S_LHDR);
        ctr_step  = (state == S_PSHIFT) || (state == S_LDATA);
        buf_put   = (state == S_PSHIFT) && cap_rec;
        buf_clear = (state == S_IDLE)
                 || ((state == S_PWR) && rom_wr_ack && !hdr_pend);
    end

    // Port outputs decoded from state
    always_comb begin
        busy        = (state != S_IDLE);
        done        = (state == S_DONE);
        chain_shift = (state == S_PSHIFT) || (state == S_LDATA);
        chain_si    = (state == S_PSHIFT) ? chain_so
                    : (state == S_LDATA)  ? rom_rdata[wpos] : 1'b0;
        mem_bypass  = (state == S_LDATA)
                    ? ~({{(NUM_MEM-1){1'b0}}, 1'b1} << ld_idx) : '0;
        rom_addr    = addr[AW-1:0];
        rom_wr_req  = (state == S_PWR);
        rom_wdata   = hdr_pend ? hdr_word : wbuf;
    end

    // Pass sequencing, address pointer and record bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            addr      <= '0;
            stored    <= '0;
            rec_on    <= 1'b0;
            hdr_pend  <= 1'b0;
            word_pend <= 1'b0;
            rec_mem   <= '0;
            ld_idx    <= '0;
        end else begin
            case (state)
                S_IDLE: begin
                    addr      <= '0;
                    stored    <= '0;
                    rec_on    <= 1'b0;
                    hdr_pend  <= 1'b0;
                    word_pend <= 1'b0;
                    if (prog_start)      state <= S_SCAN;
                    else if (load_start) state <= S_LHDR;
                end
                S_SCAN: begin
                    if (rd_end) begin
                        state <= S_PSHIFT;
                    end else begin
                        if (rd_ok) stored[rd_idx] <= 1'b1;
                        addr <= addr + CW'(REC_WRDS);
                    end
                end
                S_PSHIFT: begin
                    rec_on <= cap_rec;
                    if (cap_rec && (bit_idx == '0)) begin
                        hdr_pend <= 1'b1;
                        rec_mem  <= mem_idx[IDX_W-1:0];
                    end
                    if (cap_rec && word_end) word_pend <= 1'b1;
                    if (cap_rec && ((bit_idx == '0) || word_end))
                        state <= S_PWR;
                    else if (last_bit && last_mem)
                        state <= S_DONE;
                end
                S_PWR: begin
                    if (rom_wr_ack) begin
                        addr <= addr + 1'b1;
                        if (hdr_pend) begin
                            hdr_pend <= 1'b0;
                            if (!word_pend)
                                state <= all_done ? S_DONE : S_PSHIFT;
                        end else begin
                            word_pend <= 1'b0;
                            state     <= all_done ? S_DONE : S_PSHIFT;
                        end
                    end
                end
                S_LHDR: begin
                    if (rd_end) begin
                        state <= S_DONE;
                    end else if (rd_ok) begin
                        ld_idx <= rd_idx;
                        addr   <= addr + 1'b1;
                        state  <= S_LDATA;
                    end else begin
                        addr <= addr + CW'(REC_WRDS);
                    end
                end
                S_LDATA: begin
                    if (word_end) addr  <= addr + 1'b1;
                    if (last_bit) state <= S_LHDR;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/fuse_rom_programmer_chk.sv
// Cycle-level rules of the repair fuse word programmer, bound to the top.
// Assumes the same parameters as the bound instance.
module fuse_rom_programmer_chk #(
    parameter int NUM_MEM   = 4,
    parameter int ROM_W     = 4,
    parameter int ROM_DEPTH = 16
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         busy,
    input logic                         done,
    input logic                         chain_shift,
    input logic [NUM_MEM-1:0]           mem_bypass,
    input logic [$clog2(ROM_DEPTH)-1:0] rom_addr,
    input logic                         rom_wr_req,
    input logic [ROM_W-1:0]             rom_wdata,
    input logic                         rom_wr_ack
);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!chain_shift && !rom_wr_req && !done));

    // R7
    no_shift_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rom_wr_req |-> !chain_shift);

    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_wr_req && !rom_wr_ack) |=>
            (rom_wr_req && $stable(rom_addr) && $stable(rom_wdata)));

    // R6
    wr_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rom_wr_req |-> (int'(rom_addr) < ROM_DEPTH));

    // R2
    prog_open_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rom_wr_req |-> (mem_bypass == '0));

    // R8
    one_mem_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chain_shift && (mem_bypass != '0)) |-> ($countones(~mem_bypass) == 1));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

endmodule

bind fuse_rom_programmer fuse_rom_programmer_chk #(
    .NUM_MEM(NUM_MEM), .ROM_W(ROM_W), .ROM_DEPTH(ROM_DEPTH)
) chk_i (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
    .chain_shift(chain_shift), .mem_bypass(mem_bypass),
    .rom_addr(rom_addr), .rom_wr_req(rom_wr_req),
    .rom_wdata(rom_wdata), .rom_wr_ack(rom_wr_ack)
);

// File: tb/fuse_rom_programmer_tb_top.sv
// Bench: models the bypassable fuse chain and a fuse array with a one-cycle
// acknowledge, runs three program passes and a load, and compares every
// array word and register against values computed from the requirements.
module fuse_rom_programmer_tb_top;

    localparam int M  = 4;
    localparam int L  = 6;
    localparam int W  = 4;
    localparam int D  = 10;
    localparam int AW = $clog2(D);
    localparam int NW = (L + W - 1) / W;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          prog_start = 1'b0, load_start = 1'b0;
    logic          busy, done, chain_shift, chain_si, chain_so;
    logic [M-1:0]  mem_bypass;
    logic [AW-1:0] rom_addr;
    logic [W-1:0]  rom_rdata, rom_wdata;
    logic          rom_wr_req;
    logic          rom_wr_ack = 1'b0;

    // bench-side models
    logic [L-1:0]  cq [M];
    logic [L-1:0]  c_new [M];
    logic          c_set = 1'b0, rom_clr = 1'b0;
    logic          c_in [M];
    logic [W-1:0]  rom [D];
    int            wr_count = 0;
    int            checks = 0, fails = 0, cycles = 0;

    always #2.5 clk = ~clk;

    fuse_rom_programmer #(.NUM_MEM(M), .FUSE_LEN(L), .ROM_W(W), .ROM_DEPTH(D)) dut_i (
        .clk(clk), .rst_n(rst_n), .prog_start(prog_start), .load_start(load_start),
        .busy(busy), .done(done), .chain_shift(chain_shift), .chain_si(chain_si),
        .chain_so(chain_so), .mem_bypass(mem_bypass), .rom_addr(rom_addr),
        .rom_rdata(rom_rdata), .rom_wr_req(rom_wr_req), .rom_wdata(rom_wdata),
        .rom_wr_ack(rom_wr_ack)
    );

    // serial path through bypass muxes, memory M-1 nearest chain_si
    always_comb begin
        logic s;
        s = chain_si;
        for (int i = M - 1; i >= 0; i--) begin
            c_in[i] = s;
            s = mem_bypass[i] ? s : cq[i][0];
        end
        chain_so = s;
    end

    // fuse registers: preload or shift toward bit 0
    always @(posedge clk) begin
        for (int i = 0; i < M; i++) begin
            if (c_set) cq[i] <= c_new[i];
            else if (chain_shift && !mem_bypass[i]) cq[i] <= {c_in[i], cq[i][L-1:1]};
        end
    end

    assign rom_rdata = (int'(rom_addr) < D) ? rom[rom_addr] : '0;

    // fuse array with acknowledge one cycle after request
    always @(posedge clk) begin
        rom_wr_ack <= rom_wr_req && !rom_wr_ack;
        if (rom_clr) begin
            for (int a = 0; a < D; a++) rom[a] <= '0;
        end else if (rom_wr_req && rom_wr_ack && int'(rom_addr) < D) begin
            rom[rom_addr] <= rom_wdata;
            wr_count <= wr_count + 1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] data_word(input logic [L-1:0] d, input int k);
        logic [W-1:0] w;
        w = '0;
        for (int j = 0; j < W; j++)
            if (k * W + j < L) w[j] = d[k * W + j];
        return w;
    endfunction

    task automatic set_chain(input logic [L-1:0] v0, v1, v2, v3);
        @(negedge clk);
        c_new[0] = v0; c_new[1] = v1; c_new[2] = v2; c_new[3] = v3;
        c_set = 1'b1;
        @(negedge clk);
        c_set = 1'b0;
    endtask

    // run one pass and check the end-of-pass pulse (R10)
    task automatic run_pass(input bit prog);
        @(negedge clk);
        if (prog) prog_start = 1'b1; else load_start = 1'b1;
        @(negedge clk);
        prog_start = 1'b0; load_start = 1'b0;
        while (!done) @(negedge clk);
        @(negedge clk);
        chk("R10 done one cycle", {30'd0, done, busy}, 0);
    endtask

    // expected array image: list of (memory, data) records then zeros
    task automatic check_rom(input string req, input int n,
                             input int idx [3], input logic [L-1:0] dat [3]);
        logic [W-1:0] e [D];
        int p;
        for (int a = 0; a < D; a++) e[a] = '0;
        p = 0;
        for (int r = 0; r < n; r++) begin
            e[p] = W'((1 << (W - 1)) | idx[r]);
            for (int k = 0; k < NW; k++) e[p + 1 + k] = data_word(dat[r], k);
            p += 1 + NW;
        end
        for (int a = 0; a < D; a++) chk(req, int'(rom[a]), int'(e[a]));
    endtask

    initial begin
        int ix [3];
        logic [L-1:0] dx [3];
        int wr0;
        rom_clr = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rom_clr = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", int'(busy), 0);
        chk("R1 shift", int'(chain_shift), 0);
        chk("R1 write", int'(rom_wr_req), 0);

        // pass 1: mem0 and mem2 repaired; mem1 nonzero but bit0 clear (R3)
        set_chain(6'h2D, 6'h36, 6'h13, 6'h00);
        wr0 = wr_count;
        run_pass(1'b1);
        ix = '{0, 2, 0}; dx = '{6'h2D, 6'h13, 6'h00};
        check_rom("R3 R4 first pass image", 2, ix, dx);
        chk("R4 write count", wr_count - wr0, 2 * (1 + NW));
        // R2 chain restored
        chk("R2 mem0", int'(cq[0]), 'h2D);
        chk("R2 mem1", int'(cq[1]), 'h36);
        chk("R2 mem2", int'(cq[2]), 'h13);
        chk("R2 mem3", int'(cq[3]), 'h00);

        // pass 2: mem0 changed but already stored, mem1 newly repaired (R5)
        set_chain(6'h3F, 6'h27, 6'h13, 6'h00);
        wr0 = wr_count;
        run_pass(1'b1);
        ix = '{0, 2, 1}; dx = '{6'h2D, 6'h13, 6'h27};
        check_rom("R5 append image", 3, ix, dx);
        chk("R5 write count", wr_count - wr0, 1 + NW);

        // pass 3: mem3 repaired but its record does not fit (R6)
        set_chain(6'h3F, 6'h27, 6'h13, 6'h19);
        wr0 = wr_count;
        run_pass(1'b1);
        check_rom("R6 full image", 3, ix, dx);
        chk("R6 no write", wr_count - wr0, 0);

        // load after power-up clear, records stored out of order (R8, R9)
        set_chain(6'h00, 6'h00, 6'h00, 6'h00);
        run_pass(1'b0);
        chk("R8 mem0", int'(cq[0]), 'h2D);
        chk("R8 mem1", int'(cq[1]), 'h27);
        chk("R8 mem2", int'(cq[2]), 'h13);
        chk("R9 mem3 untouched", int'(cq[3]), 'h00);

        // load with a set value in an unrecorded memory (R9)
        set_chain(6'h00, 6'h00, 6'h00, 6'h2A);
        run_pass(1'b0);
        chk("R9 mem3 kept", int'(cq[3]), 'h2A);
        chk("R8 mem1 reload", int'(cq[1]), 'h27);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    // watchdog
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 50000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected done", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule